// File: doc/BRIEF.md
# Prescaled Interrupt Timer

This block is an 8-bit interrupt timer that sits in a cartridge memory mapper. It runs on the CPU bus clock (M2) and watches CPU writes in the upper address space. It decodes two registers from those writes: a counter-load register and a control register. A prescaler counts M2 cycles while the timer is enabled and moves the counter up by one at each prescaler boundary. When the counter rolls over from 255 to 0, the block raises a level interrupt. The interrupt stays high until software acknowledges it.

The prescaler phase is unusual. After counting is enabled from an idle state, the first counter step comes at half a prescaler period. Every later step comes a full period after the one before. Software sets up the timer in four steps: it disables the timer, loads a start value, enables counting, and then waits for the interrupt. It acknowledges the interrupt either by writing a new count or by disabling the timer.

Top module: `m2_irq_timer`

## Requirements
- R1: A write selects a register only through the address bits kept by the mask 0xF00C. A masked value of 0xF000 selects counter-load and a masked value of 0xF008 selects control. Any other address, and any bus cycle with wr_en_i low, changes nothing.
- R2: A counter-load write sets the counter to data_i and drops irq_o on the next edge.
- R3: A control write with data bit 0 set turns counting on and changes neither the counter nor the prescaler. Repeating this write while counting is already on does not move the next increment.
- R4: A control write with data bit 0 clear has four effects: counting stops, the prescaler is zeroed, the half-period phase is re-armed and irq_o drops.
- R5: From a re-armed state, the first counter increment lands on the 128th clock edge after the enabling write's edge.
- R6: Every increment after the first lands exactly 256 edges after the previous one.
- R7: irq_o rises on the edge where the counter wraps from 255 to 0. It then stays high, even across later wraps, until an R2 or R4 write.
- R8: An asynchronous reset leaves four states: counter 0, prescaler 0, counting off and half-period phase armed, with irq_o low.
- R9: When a counter-load write falls on the same edge as an increment, the loaded value wins and no wrap is taken.
- R10: When a disabling control write falls on the edge where an increment was due, the increment and any wrap it would cause are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU bus clock (M2) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, sampled on the clock edge |
| addr_i | input | 16 | CPU address |
| data_i | input | 8 | CPU write data |
| irq_o | output | 1 | Interrupt request, active high, sticky |

## Verification
Register writes and prescaler ticks can land on the same edge, so a counter-load or disabling write can meet a due increment. The bench provokes this by counting edges from the enabling write and placing a load of 255, or a disable, exactly on the 128th edge. It judges the outcome by whether irq_o rises on that edge and by when the next interrupt arrives. A load of 255 that wins must produce an interrupt exactly 256 edges later. A disable that wins must leave irq_o low, and the next enable must then take the half-period path to the wrap.

// File: rtl/m2_irq_timer_pkg.sv
package m2_irq_timer_pkg;
  typedef struct packed {
    logic load;
    logic en;
    logic dis;
  } wr_cmd_t;
endpackage

// File: rtl/m2_irq_timer_decode.sv
module m2_irq_timer_decode
  import m2_irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] ADDR_MASK = 16'hF00C,
  parameter logic [15:0] LOAD_ADDR = 16'hF000,
  parameter logic [15:0] CTRL_ADDR = 16'hF008
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_bit_i,
  output wr_cmd_t           cmd_o
);
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] LOAD = ADDR_W'(LOAD_ADDR);
  localparam logic [ADDR_W-1:0] CTRL = ADDR_W'(CTRL_ADDR);

  logic hit_load, hit_ctrl;

  always_comb begin
    hit_load   = wr_en_i && ((addr_i & MASK) == LOAD);
    hit_ctrl   = wr_en_i && ((addr_i & MASK) == CTRL);
    cmd_o.load = hit_load;
    cmd_o.en   = hit_ctrl && en_bit_i;
    cmd_o.dis  = hit_ctrl && !en_bit_i;
  end
endmodule

// File: rtl/m2_irq_timer_prescaler.sv
module m2_irq_timer_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic dis_wr_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] HALF_LAST = PRE_W'((1 << (PRE_W - 1)) - 1);
  localparam logic [PRE_W-1:0] FULL_LAST = '1;

  logic             en_q, first_q;
  logic [PRE_W-1:0] pre_q;

  // a disabling write on a due edge swallows the step
  assign tick_o = en_q && !dis_wr_i &&
                  (first_q ? (pre_q == HALF_LAST) : (pre_q == FULL_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      first_q <= 1'b1;
      pre_q   <= '0;
    end else if (dis_wr_i) begin
      en_q    <= 1'b0;
      first_q <= 1'b1;
      pre_q   <= '0;
    end else begin
      if (en_wr_i) en_q <= 1'b1;
      if (en_q) begin
        if (tick_o) begin
          first_q <= 1'b0;
          pre_q   <= '0;
        end else begin
          pre_q   <= pre_q + 1'b1;
        end
      end
    end
  end

  AST_DIS_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wr_i |=> (!en_q && first_q && pre_q == '0)); // R4
  AST_EN_KEEPS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_q) |=> (pre_q == $past(pre_q) && first_q == $past(first_q))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !dis_wr_i) |=> $stable(pre_q)); // R3
endmodule

// File: rtl/m2_irq_timer_counter.sv
module m2_irq_timer_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      irq_q <= 1'b0;
    end else begin
      if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX) irq_q <= 1'b1;
      end
      if (clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_LOAD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !irq_q); // R2
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i))); // R9
  AST_WRAP_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (cnt_q == '0 && $past(cnt_q) == CNT_MAX)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !load_i && !clr_i) |=> irq_q); // R7
  AST_CLR_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_q); // R4
endmodule

// File: rtl/m2_irq_timer.sv
module m2_irq_timer
  import m2_irq_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              irq_o
);
  wr_cmd_t cmd;
  logic    tick;

  m2_irq_timer_decode #(.ADDR_W(ADDR_W)) i_decode (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .en_bit_i (data_i[0]),
    .cmd_o    (cmd)
  );

  m2_irq_timer_prescaler #(.PRE_W(PRE_W)) i_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_wr_i  (cmd.en),
    .dis_wr_i (cmd.dis),
    .tick_o   (tick)
  );

  m2_irq_timer_counter #(.CNT_W(DATA_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd.load),
    .load_val_i (data_i),
    .clr_i      (cmd.dis),
    .tick_i     (tick),
    .irq_o      (irq_o)
  );

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd.load, cmd.en, cmd.dis})); // R1
  AST_DIS_NO_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.dis |=> !irq_o); // R10
endmodule

// File: tb/test_m2_irq_timer.sv
module test_m2_irq_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  m2_irq_timer i_m2_irq_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .data_i(data_i), .irq_o(irq_o)
  );

  task automatic chk(input logic exp, input string req);
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s: irq_o=%b expected %b at %0t", req, irq_o, exp, $time);
    end
  endtask

  // called at a negedge; the write lands on the next posedge, returns at the following negedge
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic we = 1'b1);
    wr_en_i = we; addr_i = a; data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = '0; data_i = '0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic setup(input logic [7:0] v);
    wr(16'hF008, 8'h00);
    wr(16'hF000, v);
  endtask

  task automatic t_reset_count;
    chk(1'b0, "R8 irq after reset");
    edges(300);
    chk(1'b0, "R8 idle while disabled");
    wr(16'hF008, 8'h01);
    edges(65407);
    chk(1'b0, "R8 counter from 0, before wrap");
    edges(1);
    chk(1'b1, "R8 counter from 0, wrap at 128+255*256");
  endtask

  task automatic t_half_phase;
    setup(8'hFF);
    chk(1'b0, "R2 load clears irq");
    wr(16'hF008, 8'h01);
    edges(127);
    chk(1'b0, "R5 before first step");
    edges(1);
    chk(1'b1, "R5 first step on edge 128");
  endtask

  task automatic t_full_period;
    setup(8'hFE);
    wr(16'hF008, 8'h01);
    edges(383);
    chk(1'b0, "R6 second step not early");
    edges(1);
    chk(1'b1, "R6 second step 256 later");
  endtask

  task automatic t_reenable;
    setup(8'hFE);
    wr(16'hF008, 8'h01);
    edges(199);
    wr(16'hF008, 8'h03);
    edges(183);
    chk(1'b0, "R3 repeat enable, before wrap");
    edges(1);
    chk(1'b1, "R3 repeat enable keeps phase");
  endtask

  task automatic t_decode;
    wr(16'hF008, 8'h00);
    wr(16'hF001, 8'hFF);
    wr(16'hF0F9, 8'h01);
    edges(60);
    wr(16'hE000, 8'h00);
    wr(16'hF004, 8'h00);
    wr(16'hF000, 8'h00, 1'b0);
    edges(64);
    chk(1'b0, "R1 aliases and ignored writes, before wrap");
    edges(1);
    chk(1'b1, "R1 aliased load/enable, ignored writes");
  endtask

  task automatic t_load_collision;
    setup(8'hFF);
    wr(16'hF008, 8'h01);
    edges(127);
    wr(16'hF000, 8'hFF);
    chk(1'b0, "R9 load wins over step");
    edges(255);
    chk(1'b0, "R9 loaded value, before wrap");
    edges(1);
    chk(1'b1, "R9 loaded value wraps 256 later");
  endtask

  task automatic t_disable_collision;
    setup(8'hFF);
    wr(16'hF008, 8'h01);
    edges(127);
    wr(16'hF008, 8'h00);
    chk(1'b0, "R10 disable drops due step");
    edges(300);
    chk(1'b0, "R4 stays idle after disable");
    wr(16'hF008, 8'h01);
    edges(127);
    chk(1'b0, "R4 rearmed half phase, before wrap");
    edges(1);
    chk(1'b1, "R4 rearmed half phase");
    edges(300);
    chk(1'b1, "R7 irq sticky across wraps");
    wr(16'hF000, 8'h05);
    chk(1'b0, "R2 load acknowledges irq");
  endtask

  task automatic t_disable_ack;
    setup(8'hFF);
    wr(16'hF008, 8'h01);
    edges(128);
    chk(1'b1, "R7 wrap raises irq");
    wr(16'hF008, 8'h00);
    chk(1'b0, "R4 disable acknowledges irq");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_count();
    t_half_phase();
    t_full_period();
    t_reenable();
    t_decode();
    t_load_collision();
    t_disable_collision();
    t_disable_ack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule